// File: doc/BRIEF.md
# Trellis Trace-Forward State Register Unit

This block keeps one register per trellis state of a feed-forward convolutional code with `STATE_BITS` memory elements, so `2^STATE_BITS` registers of `STATE_BITS` bits each. On every enabled step it takes the per-state survivor decisions from the add-compare-select stage. It then moves an origin-state label forward along each surviving path. Each register therefore names the trellis state from which its survivor left when tracking began. Once the survivors have merged, which takes about one decoding length of steps, every register holds the same label: the encoder state at the start of tracking.

Tracking starts with a one-cycle initialize strobe. On that step each register is loaded with the label of the predecessor its decision selects. On every later step each register copies the old contents of its selected predecessor register. All registers update on the same edge from the previous contents. A step enable freezes the whole bank, so a bank that is not tracking holds its contents and does not toggle.

Top module: `trace_fwd_bank`

## Requirements
- R1: After reset every register field of `labelsFlat` is zero and `labelsValid` is low.
- R2: On an edge with `stepEn` and `initPulse` both high, field n (bits `[n*STATE_BITS +: STATE_BITS]`) becomes `n>>1` if `decisions[n]` is 0, and `2^(STATE_BITS-1) + (n>>1)` if it is 1. This applies whatever the field held before, so it also restarts a run in progress.
- R3: On an edge with `stepEn` high and `initPulse` low, field n becomes the pre-edge value of field `n>>1` if `decisions[n]` is 0, or of field `2^(STATE_BITS-1) + (n>>1)` if it is 1. All fields use pre-edge values.
- R4: On an edge with `stepEn` low, every field keeps its value and `initPulse` and `decisions` have no effect.
- R5: `labelsValid` rises on the first edge that takes an initialize step, stays low until then (including when `initPulse` comes while `stepEn` is low), and stays high until reset.
- R6: After an initialize step followed by `STATE_BITS-1` advance steps, all with every decision 0, all fields equal 0. With every decision 1 instead, all fields equal `2^STATE_BITS - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Step enable; low freezes the bank |
| initPulse | input | 1 | Selects the initialize rule for this step |
| decisions | input | 2^STATE_BITS | Survivor decision bit per state |
| labelsFlat | output | 2^STATE_BITS * STATE_BITS | All register contents, state n at bits n*STATE_BITS upward |
| labelsValid | output | 1 | High once tracking has been initialized |

## Verification
A wrong predecessor index or a wrong seed constant changes at least one field on the very edge of the step that uses it, whenever the decision selects that path. So the bench compares the whole flattened bank after every step against a model, not only at convergence. Freeze failures show on the first disabled edge as a changed field. A wrong update order shows within one step, because a register would read a neighbour's new value instead of its old one. Convergence runs confirm that all registers settle after exactly `STATE_BITS` steps of uniform decisions.

// File: rtl/tfwd_pkg.sv
package tfwd_pkg;
  typedef struct packed {
    logic seed;
    logic advance;
  } tfwdStrobe_t;
endpackage

// File: rtl/tfwd_ctrl.sv
module tfwd_ctrl
  import tfwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepEn,
  input  logic        initPulse,
  output tfwdStrobe_t strobes,
  output logic        labelsValid
);
  always_comb begin
    strobes.seed    = stepEn && initPulse;
    strobes.advance = stepEn && !initPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             labelsValid <= 1'b0;
    else if (strobes.seed) labelsValid <= 1'b1;
  end

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    labelsValid |=> labelsValid);

  assert_valid_needs_init_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(labelsValid) |-> $past(stepEn && initPulse));
endmodule

// File: rtl/tfwd_datapath.sv
module tfwd_datapath
  import tfwd_pkg::*;
#(
  parameter int STATE_BITS = 3
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  tfwdStrobe_t                               strobes,
  input  logic [(1<<STATE_BITS)-1:0]                decisions,
  output logic [(1<<STATE_BITS)*STATE_BITS-1:0]     labelsFlat
);
  localparam int NUM_STATES = 1 << STATE_BITS;
  localparam int HALF       = NUM_STATES / 2;

  logic [STATE_BITS-1:0] labelQ [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : gState
    localparam int LO_IDX = g >> 1;
    localparam int HI_IDX = HALF + (g >> 1);
    localparam logic [STATE_BITS-1:0] LO_LABEL = STATE_BITS'(LO_IDX);
    localparam logic [STATE_BITS-1:0] HI_LABEL = STATE_BITS'(HI_IDX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        labelQ[g] <= '0;
      else if (strobes.seed)
        labelQ[g] <= decisions[g] ? HI_LABEL : LO_LABEL;
      else if (strobes.advance)
        labelQ[g] <= decisions[g] ? labelQ[HI_IDX] : labelQ[LO_IDX];
    end

    assign labelsFlat[g*STATE_BITS +: STATE_BITS] = labelQ[g];
  end

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.seed, strobes.advance}));

  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.seed || strobes.advance) |=> $stable(labelsFlat));

  assert_seed_state0_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.seed |=> labelsFlat[STATE_BITS-1:0] ==
      ($past(decisions[0]) ? STATE_BITS'(HALF) : STATE_BITS'(0)));

  assert_advance_state0_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> labelsFlat[STATE_BITS-1:0] ==
      ($past(decisions[0]) ? $past(labelQ[HALF]) : $past(labelQ[0])));
endmodule

// File: rtl/trace_fwd_bank.sv
module trace_fwd_bank
  import tfwd_pkg::*;
#(
  parameter int STATE_BITS = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  stepEn,
  input  logic                                  initPulse,
  input  logic [(1<<STATE_BITS)-1:0]            decisions,
  output logic [(1<<STATE_BITS)*STATE_BITS-1:0] labelsFlat,
  output logic                                  labelsValid
);
  tfwdStrobe_t strobes;

  tfwd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .initPulse  (initPulse),
    .strobes    (strobes),
    .labelsValid(labelsValid)
  );

  tfwd_datapath #(.STATE_BITS(STATE_BITS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .decisions (decisions),
    .labelsFlat(labelsFlat)
  );
endmodule

// File: tb/trace_fwd_bank_tb_top.sv
module trace_fwd_bank_tb_top;
  localparam int M = 3;
  localparam int N = 1 << M;
  localparam int W = N * M;

  typedef struct {
    logic [W-1:0] flat;
    logic         valid;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0;
  logic initPulse = 1'b0;
  logic [N-1:0] decisions = '0;
  logic [W-1:0] labelsFlat;
  logic labelsValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];
  logic [M-1:0] model [N];
  logic modelValid = 1'b0;

  always #5 clk = ~clk;

  trace_fwd_bank #(.STATE_BITS(M)) dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .initPulse(initPulse),
    .decisions(decisions), .labelsFlat(labelsFlat), .labelsValid(labelsValid)
  );

  function automatic logic [W-1:0] packModel();
    logic [W-1:0] f;
    for (int n = 0; n < N; n++) f[n*M +: M] = model[n];
    return f;
  endfunction

  task automatic compare(input expItem_t e);
    checks++;
    if (labelsFlat !== e.flat || labelsValid !== e.valid) begin
      errors++;
      $display("FAIL %s: flat=%h valid=%b expected flat=%h valid=%b",
               e.tag, labelsFlat, labelsValid, e.flat, e.valid);
    end
  endtask

  // driver: one step per cycle, expectation queued for the monitor
  task automatic doStep(input logic en, input logic ini, input logic [N-1:0] dec,
                        input string tag);
    logic [M-1:0] old [N];
    expItem_t e;
    @(negedge clk);
    stepEn = en; initPulse = ini; decisions = dec;
    for (int n = 0; n < N; n++) old[n] = model[n];
    if (en && ini) begin
      for (int n = 0; n < N; n++)
        model[n] = dec[n] ? M'(N/2 + (n >> 1)) : M'(n >> 1);
      modelValid = 1'b1;
    end else if (en) begin
      for (int n = 0; n < N; n++)
        model[n] = dec[n] ? old[N/2 + (n >> 1)] : old[n >> 1];
    end
    e.flat = packModel(); e.valid = modelValid; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  task automatic checkUniform(input logic [M-1:0] v, input string tag);
    @(negedge clk);
    stepEn = 1'b0; initPulse = 1'b0;
    for (int n = 0; n < N; n++) begin
      checks++;
      if (labelsFlat[n*M +: M] !== v) begin
        errors++;
        $display("FAIL %s: state %0d label=%0d expected %0d", tag, n,
                 labelsFlat[n*M +: M], v);
      end
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish();
  end

  initial begin
    logic [15:0] lfsr;
    expItem_t e;
    for (int n = 0; n < N; n++) model[n] = '0;
    repeat (3) @(posedge clk);
    #2;
    e.flat = '0; e.valid = 1'b0; e.tag = "R1 reset state";
    compare(e);
    @(negedge clk) rstN = 1'b1;

    // R4/R5: initialize strobe while disabled is ignored
    doStep(1'b0, 1'b1, 8'hFF, "R4 init ignored while disabled");
    doStep(1'b0, 1'b1, 8'h5A, "R5 valid stays low without enable");
    // R2: seed rule
    doStep(1'b1, 1'b1, 8'b1011_0010, "R2 seed pattern A");
    // R3: advance with varied decisions
    doStep(1'b1, 1'b0, 8'b0110_1001, "R3 advance step 1");
    doStep(1'b1, 1'b0, 8'b1100_0011, "R3 advance step 2");
    // R4: freeze with init and decisions toggling
    doStep(1'b0, 1'b1, 8'hA5, "R4 hold with init high");
    doStep(1'b0, 1'b0, 8'h3C, "R4 hold with decisions changing");
    doStep(1'b1, 1'b0, 8'b1000_0001, "R3 advance step 3");
    // R2: reseed mid-run
    doStep(1'b1, 1'b1, 8'b0100_1110, "R2 reseed mid-run");
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doStep(lfsr[8], (lfsr[3:0] == 4'h0), lfsr[7:0], "R3 random stepping");
    end
    // R6: convergence with all-zero decisions
    doStep(1'b1, 1'b1, '0, "R6 zero-decision seed");
    for (int i = 0; i < M - 1; i++) doStep(1'b1, 1'b0, '0, "R6 zero-decision advance");
    checkUniform('0, "R6 converged to zero");
    // R6: convergence with all-one decisions
    doStep(1'b1, 1'b1, '1, "R6 one-decision seed");
    for (int i = 0; i < M - 1; i++) doStep(1'b1, 1'b0, '1, "R6 one-decision advance");
    checkUniform('1, "R6 converged to all ones");
    doStep(1'b0, 1'b0, '0, "R4 final hold");
    repeat (3) @(posedge clk);
    #3;
    finish();
  end
endmodule